// File: doc/BRIEF.md
# I2C Dual-Rate SCL Timing Generator

This block sets the pace of an I2C master's clock line. A source clock is first divided by a fixed integer prescaler. The prescaled tick then drives two nested counters. The inner counter (the step counter) wraps once per sampling interval and emits a sample strobe. The outer counter (the sample counter) counts those strobes and flips the SCL phase after a programmed number of them. One SCL half period therefore lasts prescaler × step count × sample count source cycles. The bus rate is the prescaled clock divided by twice the product of the two counts.

Two timing words feed the counters. The normal word paces standard and fast operation, and also the master-code byte of a high-speed transfer. The high-speed word has its own field layout, a narrower step field and a two-bit enable code. The byte sequencer pulses a "master code done" input. If the high-speed word is enabled, the generator moves to the high-speed word at the next SCL phase boundary, so the repeated start that follows already runs at the fast rate. Timing values are taken only while the generator is stopped and at phase boundaries, so no half period is ever cut short. The block also presents the start-condition hold setting that suits the current bus class. The byte sequencer and the pad drivers sit outside this block.

Top module: `i2c_rate_gen`

## Requirements
- R1: While `run_i` is low, and after reset, `scl_o` is 1, all three strobes are 0 and `hs_active_o` is 0.
- R2: While running, `sample_o` pulses once every `CLK_DIV`×(S+1) cycles. S is the step field in force and `CLK_DIV` is the fixed prescaler.
- R3: In the normal word, bits [5:0] hold S (step count minus one) and bits [10:8] hold P (sample count minus one). A half period lasts H = `CLK_DIV`×(S+1)×(P+1) cycles. The first phase strobe after `run_i` rises is a fall, seen after the H-th clock edge at which `run_i` is high.
- R4: Phase strobes alternate between `scl_fall_o` and `scl_rise_o`. After a fall `scl_o` is 0, and after a rise it is 1. Every phase strobe comes together with a `sample_o` pulse.
- R5: The extreme settings work: S=0 with P=0 gives H=`CLK_DIV`, and S=63 with P=7 gives H=512×`CLK_DIV`.
- R6: In the high-speed word, bits [10:8] hold S (so at most 8 steps), bits [14:12] hold P, and bits [1:0] equal to 2'b11 mean high-speed is enabled.
- R7: A one-cycle `mc_done_i` pulse with high-speed enabled does not alter the current half period. At the next phase boundary `hs_active_o` rises, and all later half periods use the high-speed word. `hs_active_o` stays high while `run_i` stays high.
- R8: When bits [1:0] of the high-speed word are not 2'b11, `mc_done_i` is ignored: `hs_active_o` stays 0 and the normal timing continues.
- R9: If `mc_done_i` is high in the same cycle as a phase boundary, the switch happens at that same boundary.
- R10: A change to the normal word in the middle of a half period takes effect only from the next phase boundary.
- R11: Lowering `run_i` returns the block to the R1 state and clears high-speed mode. The next run starts again with a fall after a full H.
- R12: `start_hold_o` is 16'h8001 when `slow_bus_i` is 1 (bus at or below 100 kHz) and 16'h1800 otherwise.
- R13: Timing words are taken while `run_i` is low. Words written in the cycle before `run_i` rises are the ones in force for the first half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Generator runs while high; idle and cleared while low |
| std_timing_i | input | 16 | Normal timing word: step-1 in [5:0], sample-1 in [10:8] |
| hs_timing_i | input | 16 | High-speed word: enable code [1:0], step-1 in [10:8], sample-1 in [14:12] |
| slow_bus_i | input | 1 | 1 when the bus runs at or below 100 kHz |
| mc_done_i | input | 1 | One-cycle pulse from the sequencer when the master-code byte is finished |
| scl_o | output | 1 | Current SCL phase level (1 = high phase) |
| scl_fall_o | output | 1 | One-cycle strobe when SCL moves to its low phase |
| scl_rise_o | output | 1 | One-cycle strobe when SCL moves to its high phase |
| sample_o | output | 1 | One-cycle sampling strobe at each step-counter wrap |
| hs_active_o | output | 1 | High while the high-speed word paces the counters |
| start_hold_o | output | 16 | Start-condition hold setting for the current bus class |

## Verification
The master-code notice and a phase boundary can land in the same cycle. The bench provokes this by holding `mc_done_i` high exactly during the clock edge that ends a half period. It then checks three things: the phase strobe appears, `hs_active_o` is already high in that cycle, and the next half period has the high-speed length. A second collision is a write to the normal word that arrives mid-period. Here the bench checks that the running half period keeps its old length and that the following one takes the new length.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;

  localparam int unsigned STEP_W = 6;
  localparam int unsigned SMP_W  = 3;

  localparam logic [15:0] HOLD_STD  = 16'h8001;
  localparam logic [15:0] HOLD_FAST = 16'h1800;

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic [SMP_W-1:0]  smp;
  } lim_t;

  // normal word: step-1 at [5:0], sample-1 at [10:8]
  function automatic lim_t std_fields(input logic [15:0] w);
    lim_t l;
    l.step = w[5:0];
    l.smp  = w[10:8];
    return l;
  endfunction

  // high-speed word: step-1 at [10:8], sample-1 at [14:12]
  function automatic lim_t hs_fields(input logic [15:0] w);
    lim_t l;
    l.step = {3'b000, w[10:8]};
    l.smp  = w[14:12];
    return l;
  endfunction

  function automatic logic hs_enabled(input logic [15:0] w);
    return (w[1:0] == 2'b11);
  endfunction

endpackage

// File: rtl/i2c_rate_prediv.sv
module i2c_rate_prediv #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  if (DIV <= 1) begin : g_bypass
    assign tick_o = run_i;
  end else begin : g_count
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          wrap;

    assign wrap = (cnt_q == LAST);

    always_comb begin
      if (!run_i)    cnt_d = '0;
      else if (wrap) cnt_d = '0;
      else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i & wrap;
  end

endmodule

// File: rtl/i2c_rate_sel.sv
module i2c_rate_sel
  import i2c_rate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_i,
  input  logic [15:0] std_reg_i,
  input  logic [15:0] hs_reg_i,
  input  logic        mc_done_i,
  input  logic        bound_i,
  output lim_t        lim_o,
  output logic        hs_active_o
);

  lim_t lim_q, lim_d;
  logic pend_q, pend_d;
  logic act_q, act_d;
  logic arm;

  always_comb begin
    arm    = pend_q | (mc_done_i & hs_enabled(hs_reg_i));
    lim_d  = lim_q;
    pend_d = pend_q;
    act_d  = act_q;
    if (!run_i) begin
      lim_d  = std_fields(std_reg_i);
      pend_d = 1'b0;
      act_d  = 1'b0;
    end else if (bound_i) begin
      if (act_q || arm) begin
        act_d  = 1'b1;
        pend_d = 1'b0;
        lim_d  = hs_fields(hs_reg_i);
      end else begin
        lim_d  = std_fields(std_reg_i);
      end
    end else if (arm && !act_q) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      lim_q  <= lim_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign lim_o       = lim_q;
  assign hs_active_o = act_q;

endmodule

// File: rtl/i2c_rate_counter.sv
module i2c_rate_counter
  import i2c_rate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  lim_t lim_i,
  output logic bound_o,
  output logic scl_o,
  output logic fall_o,
  output logic rise_o,
  output logic sample_o
);

  logic [STEP_W-1:0] step_q, step_d;
  logic [SMP_W-1:0]  smp_q, smp_d;
  logic              scl_q, scl_d;
  logic              fall_q, fall_d;
  logic              rise_q, rise_d;
  logic              stb_q, stb_d;
  logic              step_hit;
  logic              phase_hit;

  assign step_hit  = tick_i & (step_q == lim_i.step);
  assign phase_hit = step_hit & (smp_q == lim_i.smp);

  always_comb begin
    step_d = step_q;
    smp_d  = smp_q;
    scl_d  = scl_q;
    fall_d = 1'b0;
    rise_d = 1'b0;
    stb_d  = 1'b0;
    if (!run_i) begin
      step_d = '0;
      smp_d  = '0;
      scl_d  = 1'b1;
    end else begin
      if (tick_i) begin
        step_d = step_hit ? '0 : step_q + 1'b1;
        if (step_hit) smp_d = phase_hit ? '0 : smp_q + 1'b1;
        if (phase_hit) scl_d = ~scl_q;
      end
      stb_d  = step_hit;
      fall_d = phase_hit & scl_q;
      rise_d = phase_hit & ~scl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      smp_q  <= '0;
      scl_q  <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      smp_q  <= smp_d;
      scl_q  <= scl_d;
      fall_q <= fall_d;
      rise_q <= rise_d;
      stb_q  <= stb_d;
    end
  end

  assign bound_o  = phase_hit;
  assign scl_o    = scl_q;
  assign fall_o   = fall_q;
  assign rise_o   = rise_q;
  assign sample_o = stb_q;

endmodule

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen
  import i2c_rate_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_i,
  input  logic [15:0] std_timing_i,
  input  logic [15:0] hs_timing_i,
  input  logic        slow_bus_i,
  input  logic        mc_done_i,
  output logic        scl_o,
  output logic        scl_fall_o,
  output logic        scl_rise_o,
  output logic        sample_o,
  output logic        hs_active_o,
  output logic [15:0] start_hold_o
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       tick;
  logic       bound;
  lim_t       lim;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  i2c_rate_prediv #(.DIV(CLK_DIV)) u_prediv (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .run_i  (run_i),
    .tick_o (tick)
  );

  i2c_rate_sel u_sel (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .run_i       (run_i),
    .std_reg_i   (std_timing_i),
    .hs_reg_i    (hs_timing_i),
    .mc_done_i   (mc_done_i),
    .bound_i     (bound),
    .lim_o       (lim),
    .hs_active_o (hs_active_o)
  );

  i2c_rate_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run_i    (run_i),
    .tick_i   (tick),
    .lim_i    (lim),
    .bound_o  (bound),
    .scl_o    (scl_o),
    .fall_o   (scl_fall_o),
    .rise_o   (scl_rise_o),
    .sample_o (sample_o)
  );

  assign start_hold_o = slow_bus_i ? HOLD_STD : HOLD_FAST;

endmodule

// File: rtl/i2c_rate_gen_chk.sv
module i2c_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run_i,
  input logic scl_o,
  input logic scl_fall_o,
  input logic scl_rise_o,
  input logic sample_o,
  input logic hs_active_o
);

  a_r1_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (scl_o && !hs_active_o && !scl_fall_o && !scl_rise_o && !sample_o));

  a_r4_one_edge_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall_o && scl_rise_o));

  a_r4_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |-> !scl_o);

  a_r4_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |-> scl_o);

  a_r4_phase_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall_o || scl_rise_o) |-> sample_o);

  a_r7_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_active_o) |-> (scl_fall_o || scl_rise_o));

  a_r7_hs_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_active_o && run_i) |=> hs_active_o);

endmodule

bind i2c_rate_gen i2c_rate_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .run_i       (run_i),
  .scl_o       (scl_o),
  .scl_fall_o  (scl_fall_o),
  .scl_rise_o  (scl_rise_o),
  .sample_o    (sample_o),
  .hs_active_o (hs_active_o)
);

// File: tb/i2c_rate_gen_tb.sv
`timescale 1ns/1ps
module i2c_rate_gen_tb;

  localparam int DIV = 2;

  logic        clk;
  logic        rst_n;
  logic        run_i;
  logic [15:0] std_timing_i;
  logic [15:0] hs_timing_i;
  logic        slow_bus_i;
  logic        mc_done_i;
  logic        scl_o, scl_fall_o, scl_rise_o, sample_o, hs_active_o;
  logic [15:0] start_hold_o;

  int total = 0;
  int bad   = 0;
  logic seen_fall, seen_rise, seen_smp;

  i2c_rate_gen #(.CLK_DIV(DIV)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .std_timing_i (std_timing_i),
    .hs_timing_i  (hs_timing_i),
    .slow_bus_i   (slow_bus_i),
    .mc_done_i    (mc_done_i),
    .scl_o        (scl_o),
    .scl_fall_o   (scl_fall_o),
    .scl_rise_o   (scl_rise_o),
    .sample_o     (sample_o),
    .hs_active_o  (hs_active_o),
    .start_hold_o (start_hold_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int half(input int s, input int p);
    return DIV * (s + 1) * (p + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_phase(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      cyc();
      n++;
      if (scl_fall_o || scl_rise_o) begin
        seen_fall = scl_fall_o;
        seen_rise = scl_rise_o;
        seen_smp  = sample_o;
        return;
      end
    end
    n = -1;
  endtask

  task automatic wait_sample(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      cyc();
      n++;
      if (sample_o) return;
    end
    n = -1;
  endtask

  task automatic start(input logic [15:0] sw, input logic [15:0] hw);
    std_timing_i = sw;
    hs_timing_i  = hw;
    cyc();
    run_i = 1'b1;
  endtask

  task automatic stop();
    run_i = 1'b0;
    cyc();
    cyc();
  endtask

  task automatic pulse_mc();
    mc_done_i = 1'b1;
    cyc();
    mc_done_i = 1'b0;
  endtask

  task automatic t_reset();
    check(scl_o == 1'b1, "R1 scl idle", int'(scl_o), 1);
    check(!scl_fall_o && !scl_rise_o && !sample_o, "R1 strobes idle",
          int'({scl_fall_o, scl_rise_o, sample_o}), 0);
    check(hs_active_o == 1'b0, "R1 hs idle", int'(hs_active_o), 0);
    slow_bus_i = 1'b1;
    #1;
    check(start_hold_o == 16'h8001, "R12 slow hold", int'(start_hold_o), 'h8001);
    slow_bus_i = 1'b0;
    #1;
    check(start_hold_o == 16'h1800, "R12 fast hold", int'(start_hold_o), 'h1800);
  endtask

  task automatic t_std();
    int n;
    start(16'h0103, 16'h0000);
    wait_phase(n);
    check(n == half(3, 1), "R3 R13 first half", n, half(3, 1));
    check(seen_fall && scl_o == 1'b0, "R4 first is fall", int'(scl_o), 0);
    check(seen_smp == 1'b1, "R4 sample with phase", int'(seen_smp), 1);
    wait_phase(n);
    check(n == half(3, 1), "R3 second half", n, half(3, 1));
    check(seen_rise && scl_o == 1'b1, "R4 then rise", int'(scl_o), 1);
    wait_sample(n);
    check(n == DIV * 4, "R2 sample spacing", n, DIV * 4);
    stop();
  endtask

  task automatic t_extremes();
    int n;
    start(16'h0000, 16'h0000);
    wait_phase(n);
    check(n == DIV, "R5 min first", n, DIV);
    wait_phase(n);
    check(n == DIV, "R5 min second", n, DIV);
    stop();
    start(16'h073F, 16'h0000);
    wait_sample(n);
    check(n == DIV * 64, "R2 R5 max sample spacing", n, DIV * 64);
    wait_phase(n);
    check(n == half(63, 7) - DIV * 64, "R5 max rest of half", n, half(63, 7) - DIV * 64);
    wait_phase(n);
    check(n == half(63, 7), "R5 max full half", n, half(63, 7));
    stop();
  endtask

  task automatic t_hs();
    int n;
    start(16'h0103, 16'h2103);
    wait_phase(n);
    for (int i = 0; i < 5; i++) cyc();
    pulse_mc();
    check(hs_active_o == 1'b0, "R7 no early switch", int'(hs_active_o), 0);
    wait_phase(n);
    check(n == half(3, 1) - 6, "R7 current half kept", n, half(3, 1) - 6);
    check(hs_active_o == 1'b1, "R7 hs at boundary", int'(hs_active_o), 1);
    wait_phase(n);
    check(n == half(1, 2), "R6 hs half", n, half(1, 2));
    wait_phase(n);
    check(n == half(1, 2) && hs_active_o, "R7 hs stays", n, half(1, 2));
    run_i = 1'b0;
    cyc();
    check(hs_active_o == 1'b0 && scl_o == 1'b1, "R11 stop clears",
          int'({hs_active_o, scl_o}), 1);
    cyc();
    run_i = 1'b1;
    wait_phase(n);
    check(n == half(3, 1) && seen_fall, "R11 restart fresh", n, half(3, 1));
    stop();
  endtask

  task automatic t_hs_off();
    int n;
    start(16'h0103, 16'h2100);
    wait_phase(n);
    pulse_mc();
    wait_phase(n);
    check(n == half(3, 1) - 1, "R8 half unchanged", n, half(3, 1) - 1);
    wait_phase(n);
    check(n == half(3, 1), "R8 still normal", n, half(3, 1));
    check(hs_active_o == 1'b0, "R8 hs stays off", int'(hs_active_o), 0);
    stop();
  endtask

  task automatic t_coincide();
    int n;
    start(16'h0103, 16'h2103);
    wait_phase(n);
    for (int i = 0; i < half(3, 1) - 1; i++) cyc();
    mc_done_i = 1'b1;
    cyc();
    mc_done_i = 1'b0;
    check(scl_rise_o == 1'b1, "R9 boundary hit", int'(scl_rise_o), 1);
    check(hs_active_o == 1'b1, "R9 same-cycle switch", int'(hs_active_o), 1);
    wait_phase(n);
    check(n == half(1, 2), "R9 next half is hs", n, half(1, 2));
    stop();
  endtask

  task automatic t_midchange();
    int n;
    start(16'h0103, 16'h0000);
    wait_phase(n);
    for (int i = 0; i < 4; i++) cyc();
    std_timing_i = 16'h0001;
    wait_phase(n);
    check(n == half(3, 1) - 4, "R10 old length kept", n, half(3, 1) - 4);
    wait_phase(n);
    check(n == half(1, 0), "R10 new length", n, half(1, 0));
    stop();
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    run_i        = 1'b0;
    std_timing_i = 16'h0000;
    hs_timing_i  = 16'h0000;
    slow_bus_i   = 1'b1;
    mc_done_i    = 1'b0;
    seen_fall    = 1'b0;
    seen_rise    = 1'b0;
    seen_smp     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_std();
    t_extremes();
    t_hs();
    t_hs_off();
    t_coincide();
    t_midchange();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule